// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Link

This block joins a bus master and a register-file slave over a parallel bus that has no shared clock. Each transfer is paced only by a request line owned by the master and an acknowledge line owned by the slave. The local side issues a command by raising `start` with an address, a direction and, for a write, a data word. The master places address, direction and write data on the bus. It waits a fixed number of its own clock cycles so the slave can decode the address, and only then raises request.

The slave answers with acknowledge. On a write it has stored the word by then. On a read it is already driving the register contents onto the data lines. When the master sees acknowledge it drops request, and on a read it takes the data in that same step. The slave then drops acknowledge and releases the data lines. The master completes the command with a one-cycle `done` pulse only after it has seen acknowledge low. A new address therefore never overlaps the tail of the previous transfer.

Each handshake line crosses into the other clock domain through a two-flop synchronizer. Each crossing costs three receiving-clock edges, from the edge that sets the line to the edge that acts on it. With both sides clocked alike and a decode delay of D cycles, counted from the edge that accepts `start`, the events fall on these edges: request rises at D, acknowledge rises at D+3, request falls at D+6, acknowledge falls at D+9, and `done` is high for the cycle after edge D+12.

Top module: `fourphase_link`

## Requirements
- R1: While either reset is low, and in the first cycle after it, `busReq`, `busAck`, `done`, `busy` and `slvDriving` are 0 and `rdata` is 0. All slave registers are cleared to 0.
- R2: A `start` accepted while idle latches `addr`, `writeOp` and `wdata` onto the bus at once. `busReq` rises exactly DECODE_CYC master cycles later, where DECODE_CYC is at least 1. `busAddr` holds its value for as long as `busy` is high.
- R3: `busAck` rises only while `busReq` is high, three slave edges after request rises.
- R4: `busReq` falls only while `busAck` is high. `busAck` falls only after `busReq` is low, three slave edges after request falls.
- R5: A write (`writeOp`=1) stores `wdata` into slave register `addr` when acknowledge rises. A later read of that address returns the stored word.
- R6: A read (`writeOp`=0) returns the addressed register on `rdata`, captured in the step where request falls. `rdata` then holds until the next read completes, and writes leave it unchanged.
- R7: The slave drives the data lines (`slvDriving`=1) only during a read and only while `busAck` is high. It releases them in the step in which it drops acknowledge. Master and slave never drive the data lines at once.
- R8: `done` is a one-cycle pulse, issued three master edges after acknowledge falls. `busy` is high from the accepting edge until `done` rises. A `start` raised while `busy` is high is ignored.
- R9: A `start` that is high during the `done` cycle is accepted on the next edge. Back-to-back commands then follow with no gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mClk | input | 1 | Master-side clock |
| mRstN | input | 1 | Master-side reset, active low |
| sClk | input | 1 | Slave-side clock |
| sRstN | input | 1 | Slave-side reset, active low |
| start | input | 1 | Command strobe, accepted when idle |
| writeOp | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Target register index |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Last read result |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Command in progress |
| busReq | output | 1 | Bus request line (master) |
| busAck | output | 1 | Bus acknowledge line (slave) |
| busAddr | output | ADDR_W | Bus address lines |
| busData | output | DATA_W | Resolved bus data lines |
| slvDriving | output | 1 | Slave drives the data lines |

## Verification
Two functions can meet in one cycle: the completion of one command and the acceptance of the next. The bench holds `start` high across the `done` cycle with a fresh command. It then checks that the new transfer's request rises DECODE_CYC edges after the edge following `done`, with the new address already on the bus. It also raises `start` with a different command in the middle of a transfer. The reference model shows that the bus address, the data captured in the slave and the final `rdata` all still belong to the command first accepted.

// File: rtl/fp_pkg.sv
package fp_pkg;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_SETUP = 2'd1,
    M_REQ   = 2'd2,
    M_REL   = 2'd3
  } mstState_e;

  typedef struct packed {
    logic load;     // latch command onto bus
    logic cntDec;   // step the decode counter
    logic reqSet;   // raise request
    logic reqClr;   // drop request
    logic capture;  // sample read data
    logic finish;   // release master drive
  } mstStrobe_t;

endpackage

// File: rtl/fp_sync2.sv
module fp_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/fp_mst_dp.sv
module fp_mst_dp
  import fp_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 16,
  parameter int DECODE_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  mstStrobe_t        strb,
  input  logic              writeOp,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              ackRaw,
  output logic              cntZero,
  output logic              reqOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic              writeOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              mstDrive,
  output logic [DATA_W-1:0] rdata
);
  localparam int CW = $clog2(DECODE_CYC + 1);
  localparam logic [CW-1:0] CNT_START = CW'(DECODE_CYC - 1);

  logic [CW-1:0] cntQ;

  assign cntZero = (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrOut  <= '0;
      writeOut <= 1'b0;
      dataOut  <= '0;
      mstDrive <= 1'b0;
      cntQ     <= '0;
    end else begin
      if (strb.load) begin
        addrOut  <= addr;
        writeOut <= writeOp;
        dataOut  <= wdata;
        mstDrive <= writeOp;
        cntQ     <= CNT_START;
      end else if (strb.cntDec) begin
        cntQ <= cntQ - 1'b1;
      end
      if (strb.finish) mstDrive <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            reqOut <= 1'b0;
    else if (strb.reqSet) reqOut <= 1'b1;
    else if (strb.reqClr) reqOut <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          rdata <= '0;
    else if (strb.capture && !writeOut) rdata <= busDataIn;
  end

  AST_REQ_DROP_UNDER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqOut) |-> ackRaw); // R4

endmodule

// File: rtl/fp_mst_ctrl.sv
module fp_mst_ctrl
  import fp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       ackSync,
  input  logic       cntZero,
  output mstStrobe_t strb,
  output logic       busy,
  output logic       done
);
  mstState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      M_IDLE: if (start) begin
        strb.load = 1'b1;
        stateD    = M_SETUP;
      end
      M_SETUP: if (cntZero) begin
        strb.reqSet = 1'b1;
        stateD      = M_REQ;
      end else begin
        strb.cntDec = 1'b1;
      end
      M_REQ: if (ackSync) begin
        strb.reqClr  = 1'b1;
        strb.capture = 1'b1;
        stateD       = M_REL;
      end
      M_REL: if (!ackSync) begin
        strb.finish = 1'b1;
        stateD      = M_IDLE;
      end
      default: stateD = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= M_IDLE;
      done   <= 1'b0;
    end else begin
      stateQ <= stateD;
      done   <= strb.finish;
    end
  end

  assign busy = (stateQ != M_IDLE);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy || $past(stateQ == M_REL)); // R8

endmodule

// File: rtl/fp_slave.sv
module fp_slave #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqSync,
  input  logic              reqRaw,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              writeIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              ackOut,
  output logic              drvOut,
  output logic [DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackOut  <= 1'b0;
      drvOut  <= 1'b0;
      dataOut <= '0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (!ackOut && reqSync) begin
      ackOut <= 1'b1;
      if (writeIn) begin
        regs[addrIn] <= dataIn;
      end else begin
        drvOut  <= 1'b1;
        dataOut <= regs[addrIn];
      end
    end else if (ackOut && !reqSync) begin
      ackOut <= 1'b0;
      drvOut <= 1'b0;
    end
  end

  AST_ACK_RISE_UNDER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOut) |-> reqRaw); // R3

  AST_ACK_FALL_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackOut) |-> !reqRaw); // R4

  AST_DRIVE_ONLY_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    drvOut |-> ackOut); // R7

endmodule

// File: rtl/fourphase_link.sv
module fourphase_link
  import fp_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 16,
  parameter int DECODE_CYC = 3
) (
  input  logic              mClk,
  input  logic              mRstN,
  input  logic              sClk,
  input  logic              sRstN,
  input  logic              start,
  input  logic              writeOp,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              busy,
  output logic              busReq,
  output logic              busAck,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  output logic              slvDriving
);
  mstStrobe_t        strb;
  logic              cntZero, ackSync, reqSync, busWrite, mstDrive;
  logic [DATA_W-1:0] mstData, slvData;

  fp_sync2 #(.W(1)) i_ackSync (.clk(mClk), .rstN(mRstN), .din(busAck), .dout(ackSync));
  fp_sync2 #(.W(1)) i_reqSync (.clk(sClk), .rstN(sRstN), .din(busReq), .dout(reqSync));

  fp_mst_ctrl i_ctrl (
    .clk(mClk), .rstN(mRstN), .start(start), .ackSync(ackSync),
    .cntZero(cntZero), .strb(strb), .busy(busy), .done(done)
  );

  fp_mst_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DECODE_CYC(DECODE_CYC)) i_dp (
    .clk(mClk), .rstN(mRstN), .strb(strb), .writeOp(writeOp), .addr(addr),
    .wdata(wdata), .busDataIn(busData), .ackRaw(busAck), .cntZero(cntZero),
    .reqOut(busReq), .addrOut(busAddr), .writeOut(busWrite), .dataOut(mstData),
    .mstDrive(mstDrive), .rdata(rdata)
  );

  fp_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_slave (
    .clk(sClk), .rstN(sRstN), .reqSync(reqSync), .reqRaw(busReq),
    .addrIn(busAddr), .writeIn(busWrite), .dataIn(busData),
    .ackOut(busAck), .drvOut(slvDriving), .dataOut(slvData)
  );

  always_comb begin
    if (slvDriving)    busData = slvData;
    else if (mstDrive) busData = mstData;
    else               busData = '0;
  end

  AST_ONE_DRIVER: assert property (@(posedge mClk) disable iff (!mRstN)
    !(slvDriving && mstDrive)); // R7

  AST_ADDR_HELD: assert property (@(posedge mClk) disable iff (!mRstN)
    (busy && $past(busy)) |-> $stable(busAddr)); // R2

endmodule

// File: tb/test_fourphase_link.sv
module test_fourphase_link;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int D  = 3;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, writeOp = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, busData;
  logic done, busy, busReq, busAck, slvDriving;
  logic [AW-1:0] busAddr;

  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fourphase_link #(.ADDR_W(AW), .DATA_W(DW), .DECODE_CYC(D)) i_fourphase_link (
    .mClk(clk), .mRstN(rstN), .sClk(clk), .sRstN(rstN),
    .start(start), .writeOp(writeOp), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .busy(busy), .busReq(busReq), .busAck(busAck),
    .busAddr(busAddr), .busData(busData), .slvDriving(slvDriving)
  );

  // behavioural reference model
  bit            mActive = 0, mDone = 0, mWrite = 0;
  int            mE = 0;
  logic [AW-1:0] mAddr = '0;
  logic [DW-1:0] mData = '0, mRdata = '0;
  logic [DW-1:0] mMem [1<<AW];
  int            accepted = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mActive = 0; mDone = 0; mE = 0; mRdata = '0;
      for (int i = 0; i < (1<<AW); i++) mMem[i] = '0;
    end else begin
      mDone = 0;
      if (mActive) begin
        mE++;
        if (mE == D + 3 && mWrite) mMem[mAddr] = mData;
        if (mE == D + 6 && !mWrite) mRdata = mMem[mAddr];
        if (mE == D + 12) begin mActive = 0; mDone = 1; end
      end else if (start) begin
        mActive = 1; mE = 0; mWrite = writeOp; mAddr = addr; mData = wdata;
        accepted++;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  bit inReset = 1;
  always @(negedge clk) begin
    if (inReset) begin
      check("R1 busReq", busReq, 0);
      check("R1 busAck", busAck, 0);
      check("R1 done", done, 0);
      check("R1 busy", busy, 0);
      check("R1 slvDriving", slvDriving, 0);
      check("R1 rdata", rdata, 0);
    end else begin
      bit expReq, expAck, expDrv;
      expReq = mActive && mE >= D && mE <= D + 5;
      expAck = mActive && mE >= D + 3 && mE <= D + 8;
      expDrv = expAck && !mWrite;
      check("R2 busReq", busReq, expReq);
      check("R3 busAck", busAck, expAck);
      check("R7 slvDriving", slvDriving, expDrv);
      check("R6 rdata", rdata, mRdata);
      check("R8 done", done, mDone);
      check("R8 busy", busy, mActive);
      if (mActive) check("R2 busAddr", busAddr, mAddr);
      if (expDrv) check("R5 busData", busData, mMem[mAddr]);
    end
  end

  task automatic issue(bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    start = 1; writeOp = w; addr = a; wdata = d;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);  // first cycle after reset still idle (R1)
    inReset = 0;

    // R5: writes of several patterns
    issue(1, 3'd0, 16'hA5A5);
    issue(1, 3'd7, 16'hFFFF);
    issue(1, 3'd3, 16'h0001);
    // R6: reads, including an unwritten register
    issue(0, 3'd7, '0);
    issue(0, 3'd0, '0);
    issue(0, 3'd5, '0);
    issue(1, 3'd2, 16'h1234);   // R6: write leaves rdata unchanged

    // R8: start while busy is ignored
    @(negedge clk);
    start = 1; writeOp = 1; addr = 3'd4; wdata = 16'hBEEF;
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
    start = 1; writeOp = 1; addr = 3'd3; wdata = 16'hDEAD;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    issue(0, 3'd3, '0);  // must still read 0001
    check("R8 ignored start left register", rdata, 16'h0001);

    // R9: back-to-back, start held across done
    @(negedge clk);
    start = 1; writeOp = 1; addr = 3'd6; wdata = 16'h5A5A;
    @(negedge clk);
    while (!done) @(negedge clk);
    writeOp = 0; addr = 3'd6;
    @(negedge clk);
    check("R9 accepted after done", busy, 1);
    start = 0;
    while (!done) @(negedge clk);
    check("R9 back-to-back read", rdata, 16'h5A5A);
    check("R9 command count", accepted, 11);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule